// File: doc/BRIEF.md
# MFM Sector Write Pulse Encoder

This block produces the serial write-data waveform for one floppy-style sector. After a start strobe it pulls the write gate low and emits a run of short flux intervals as a preamble. It then emits a fixed interval pattern that forms three 0xA1 sync marks with a missing clock bit. After that it encodes a byte buffer as MFM. The buffer holds the data mark, payload, CRC and trailer, which an upstream stage supplies over a valid/ready stream. The number of bytes is latched from a count input at start.

Every flux transition appears on `wr_data` as a low pulse of fixed width at the start of an interval. The waveform therefore reduces to a chain of short, medium and long intervals (2, 3 and 4 half-cells). The length of each interval comes from a three-state history machine:

- **Preamble** (`SQ_PREAMBLE`) loads short intervals.
- **Sync** (`SQ_SYNC`) loads the fixed sync sequence.
- The encoder states track the previous data bits:
  - `SQ_ENC00`: the previous bits were 00.
  - `SQ_ENCX1`: the previous bit was 1.
  - `SQ_ENC10`: the previous bits were 10.
- **Drain** (`SQ_DRAIN`) emits the pulse for the final transition.
- **Release** (`SQ_RELEASE`) raises the gate.
- **Done** (`SQ_DONE`) gives the completion strobe.
- The machine then returns to `SQ_IDLE`.

The next interval is always decided while the current one runs, so intervals follow each other with no gap. If the byte stream cannot supply data in time, the write is aborted and reported as an underrun.

Top module: `mfm_sector_writer`

## Requirements
- R1: `start` is acted on only in idle. It pulls `wr_gate_n` low and latches `byte_count`. A `start` pulse during a write is ignored, and so is a `byte_count` change during a write.
- R2: Every interval begins with `wr_data` low for `PULSE_LEN` clocks (default 8). `wr_data` is high for the rest of the interval.
- R3: Interval lengths are `SHORT_LEN`, `MEDIUM_LEN` and `LONG_LEN` clocks (defaults 32, 48, 64), which are 2, 3 and 4 half-cells of 16 clocks.
- R4: The first `PREAMBLE_LEN` intervals (default 96) are short.
- R5: After the preamble the encoder emits three sync groups of five intervals each. The first group is medium, long, medium, long, medium. The second and third groups are short, long, medium, long, medium. Encoding then resumes in `SQ_ENCX1`.
- R6: In `SQ_ENC00`, a data bit 0 loads a short interval and the state is kept. A data bit 1 loads a medium interval and moves to `SQ_ENCX1`.
- R7: In `SQ_ENCX1`, a data bit 1 loads a short interval and the state is kept. A data bit 0 loads no interval and moves to `SQ_ENC10`.
- R8: In `SQ_ENC10`, a data bit 1 loads a long interval and moves to `SQ_ENCX1`. A data bit 0 loads a medium interval and moves to `SQ_ENC00`.
- R9: Bytes are taken on `in_valid && in_ready` and encoded MSB first. Exactly `byte_count` bytes are taken. A count of zero encodes no data.
- R10: Consecutive intervals are back to back. The time from one falling edge of `wr_data` to the next equals the length of the interval that was loaded.
- R11: After the last byte, one final pulse marks the last transition. Then `wr_gate_n` goes high, `wr_data` stays high, and `done` pulses for one cycle on the cycle after the gate rises.
- R12: If an interval ends during encoding with no next interval decided, the write is aborted. No further pulse is emitted, the gate is released, and `underrun` is high together with `done`.
- R13: After reset, `wr_gate_n`=1, `wr_data`=1, `done`=0, `underrun`=0 and `in_ready`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe for one sector write |
| byte_count | input | CNT_W | Number of buffer bytes, latched at start |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | 8 | Byte stream data |
| in_ready | output | 1 | Encoder requests the next byte |
| wr_data | output | 1 | Write data, low pulse at each flux transition |
| wr_gate_n | output | 1 | Write gate, active low |
| done | output | 1 | One-cycle completion strobe |
| underrun | output | 1 | High with done when the write was aborted |

## Verification
The bench works out the expected intervals arithmetically. It runs a plain clock/data MFM expansion of each buffer and measures the distance between consecutive ones in half-cells, prefixed by the preamble and sync lists. This way a wrong transition in any of the three history states shows up as a wrong distance between two falling edges.

A full frame with every byte value sweeps all history transitions. The edge frames cover the following:
- An empty buffer, to catch a machine that skips the final pulse or hangs in drain.
- A single all-zero byte and a single all-one byte.
- A stall in the byte stream. A design that waited instead of aborting would never raise `underrun`, or would keep pulsing.
- A second start strobe with a new count in mid-write. A design that re-armed would take the wrong number of bytes.

// File: rtl/mfm_wr_pkg.sv
package mfm_wr_pkg;

    typedef enum logic [1:0] {
        IV_SHORT,
        IV_MEDIUM,
        IV_LONG,
        IV_TAIL
    } iv_kind_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_PREAMBLE,
        SQ_SYNC,
        SQ_ENC00,
        SQ_ENCX1,
        SQ_ENC10,
        SQ_DRAIN,
        SQ_RELEASE,
        SQ_DONE
    } seq_state_t;

    localparam int SYNC_STEPS = 15;

    // Fixed interval pattern forming three sync marks with a missing clock.
    function automatic iv_kind_t sync_kind(input logic [3:0] idx);
        iv_kind_t k;
        unique case (idx)
            4'd0:                 k = IV_MEDIUM;
            4'd5, 4'd10:          k = IV_SHORT;
            4'd1, 4'd6, 4'd11,
            4'd3, 4'd8, 4'd13:    k = IV_LONG;
            default:              k = IV_MEDIUM;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/mfm_interval_timer.sv
module mfm_interval_timer
    import mfm_wr_pkg::*;
#(
    parameter int SHORT_LEN  = 32,
    parameter int MEDIUM_LEN = 48,
    parameter int LONG_LEN   = 64,
    parameter int PULSE_LEN  = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pend_valid,
    input  iv_kind_t pend_kind,
    output logic     take,
    output logic     busy,
    output logic     expire_empty,
    output logic     pulse_n
);
    localparam int CW = $clog2(LONG_LEN + 1);
    localparam logic [CW-1:0] PULSE_C = CW'(PULSE_LEN);

    logic          active;
    logic [CW-1:0] cnt;
    logic [CW-1:0] len_r;
    logic          last;

    function automatic logic [CW-1:0] kind_len(input iv_kind_t k);
        logic [CW-1:0] v;
        unique case (k)
            IV_SHORT:  v = CW'(SHORT_LEN);
            IV_MEDIUM: v = CW'(MEDIUM_LEN);
            IV_LONG:   v = CW'(LONG_LEN);
            default:   v = CW'(PULSE_LEN);
        endcase
        return v;
    endfunction

    assign last         = active && (cnt == len_r - 1'b1);
    assign take         = pend_valid && (!active || last);
    assign busy         = active;
    assign expire_empty = last && !pend_valid;
    assign pulse_n      = !(active && (cnt < PULSE_C));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            len_r  <= '0;
        end else if (take) begin
            active <= 1'b1;
            cnt    <= '0;
            len_r  <= kind_len(pend_kind);
        end else if (last) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_n) && (PULSE_LEN > 1)) |=> !pulse_n);

endmodule

// File: rtl/mfm_write_sequencer.sv
module mfm_write_sequencer
    import mfm_wr_pkg::*;
#(
    parameter int PREAMBLE_LEN = 96,
    parameter int CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic             tmr_take,
    input  logic             tmr_busy,
    input  logic             tmr_expire_empty,
    output logic             pend_valid,
    output iv_kind_t         pend_kind,
    output logic             wr_gate_n,
    output logic             done,
    output logic             underrun
);
    localparam int PW = (PREAMBLE_LEN > 1) ? $clog2(PREAMBLE_LEN) : 1;
    localparam logic [PW-1:0] PRE_LAST  = PW'(PREAMBLE_LEN - 1);
    localparam logic [3:0]    SYNC_LAST = 4'(SYNC_STEPS - 1);

    seq_state_t       state, nxt;
    logic [PW-1:0]    pre_cnt;
    logic [3:0]       sync_idx;
    logic [CNT_W-1:0] bytes_left;
    logic [7:0]       shreg;
    logic [3:0]       bits_left;
    logic             pend_q;
    iv_kind_t         pend_kind_q;
    logic             tail_q;
    logic             err_q;

    logic             enc_st;
    logic             fill_en;
    iv_kind_t         fill_kind;
    logic             consume;
    logic             abort;
    logic             load_byte;

    assign enc_st    = (state == SQ_ENC00) || (state == SQ_ENCX1) || (state == SQ_ENC10);
    assign load_byte = in_ready && in_valid;

    // Decision logic: next state and the interval to queue.
    always_comb begin
        nxt       = state;
        fill_en   = 1'b0;
        fill_kind = IV_SHORT;
        consume   = 1'b0;
        abort     = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                if (start) nxt = SQ_PREAMBLE;
            end
            SQ_PREAMBLE: begin
                if (!pend_q) begin
                    fill_en = 1'b1;
                    if (pre_cnt == PRE_LAST) nxt = SQ_SYNC;
                end
            end
            SQ_SYNC: begin
                if (!pend_q) begin
                    fill_en   = 1'b1;
                    fill_kind = sync_kind(sync_idx);
                    if (sync_idx == SYNC_LAST) nxt = SQ_ENCX1;
                end
            end
            SQ_ENC00, SQ_ENCX1, SQ_ENC10: begin
                if (tmr_expire_empty) begin
                    abort = 1'b1;
                    nxt   = SQ_RELEASE;
                end else if (bits_left == 4'd0) begin
                    if (bytes_left == '0) nxt = SQ_DRAIN;
                end else if (!pend_q) begin
                    consume = 1'b1;
                    if (state == SQ_ENC00) begin
                        fill_en = 1'b1;
                        if (shreg[7]) begin
                            fill_kind = IV_MEDIUM;
                            nxt       = SQ_ENCX1;
                        end else begin
                            fill_kind = IV_SHORT;
                        end
                    end else if (state == SQ_ENCX1) begin
                        if (shreg[7]) begin
                            fill_en   = 1'b1;
                            fill_kind = IV_SHORT;
                        end else begin
                            nxt = SQ_ENC10;
                        end
                    end else begin
                        fill_en = 1'b1;
                        if (shreg[7]) begin
                            fill_kind = IV_LONG;
                            nxt       = SQ_ENCX1;
                        end else begin
                            fill_kind = IV_MEDIUM;
                            nxt       = SQ_ENC00;
                        end
                    end
                end
            end
            SQ_DRAIN: begin
                if (!pend_q && !tail_q) begin
                    fill_en   = 1'b1;
                    fill_kind = IV_TAIL;
                end else if (tail_q && !pend_q && !tmr_busy) begin
                    nxt = SQ_RELEASE;
                end
            end
            SQ_RELEASE: nxt = SQ_DONE;
            SQ_DONE:    nxt = SQ_IDLE;
            default:    nxt = SQ_IDLE;
        endcase
    end

    // State register and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= SQ_IDLE;
            pre_cnt     <= '0;
            sync_idx    <= '0;
            bytes_left  <= '0;
            shreg       <= '0;
            bits_left   <= '0;
            pend_q      <= 1'b0;
            pend_kind_q <= IV_SHORT;
            tail_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            state <= nxt;
            if (state == SQ_IDLE && start) begin
                bytes_left <= byte_count;
                bits_left  <= '0;
                pre_cnt    <= '0;
                sync_idx   <= '0;
                tail_q     <= 1'b0;
                err_q      <= 1'b0;
            end
            if (tmr_take) begin
                pend_q <= 1'b0;
            end else if (fill_en) begin
                pend_q      <= 1'b1;
                pend_kind_q <= fill_kind;
            end
            if (fill_en && state == SQ_PREAMBLE) pre_cnt  <= pre_cnt + 1'b1;
            if (fill_en && state == SQ_SYNC)     sync_idx <= sync_idx + 1'b1;
            if (fill_en && state == SQ_DRAIN)    tail_q   <= 1'b1;
            if (consume) begin
                shreg     <= {shreg[6:0], 1'b0};
                bits_left <= bits_left - 1'b1;
            end else if (load_byte) begin
                shreg      <= in_data;
                bits_left  <= 4'd8;
                bytes_left <= bytes_left - 1'b1;
            end
            if (abort) err_q <= 1'b1;
        end
    end

    // Output decode.
    always_comb begin
        in_ready   = enc_st && (bits_left == 4'd0) && (bytes_left != '0) && !tmr_expire_empty;
        pend_valid = pend_q;
        pend_kind  = pend_kind_q;
        wr_gate_n  = (state == SQ_IDLE) || (state == SQ_RELEASE) || (state == SQ_DONE);
        done       = (state == SQ_DONE);
        underrun   = (state == SQ_DONE) && err_q;
    end

    // R10
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PREAMBLE || state == SQ_SYNC) |-> !tmr_expire_empty);

    // R11
    done_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_gate_n) && $past(!done)));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    underrun_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_st && tmr_expire_empty) |=> (wr_gate_n && !tmr_busy));

endmodule

// File: rtl/mfm_sector_writer.sv
module mfm_sector_writer
    import mfm_wr_pkg::*;
#(
    parameter int SHORT_LEN    = 32,
    parameter int MEDIUM_LEN   = 48,
    parameter int LONG_LEN     = 64,
    parameter int PULSE_LEN    = 8,
    parameter int PREAMBLE_LEN = 96,
    parameter int CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             wr_data,
    output logic             wr_gate_n,
    output logic             done,
    output logic             underrun
);
    logic     pend_valid;
    iv_kind_t pend_kind;
    logic     tmr_take;
    logic     tmr_busy;
    logic     tmr_expire_empty;

    mfm_write_sequencer #(
        .PREAMBLE_LEN(PREAMBLE_LEN),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .byte_count      (byte_count),
        .in_valid        (in_valid),
        .in_data         (in_data),
        .in_ready        (in_ready),
        .tmr_take        (tmr_take),
        .tmr_busy        (tmr_busy),
        .tmr_expire_empty(tmr_expire_empty),
        .pend_valid      (pend_valid),
        .pend_kind       (pend_kind),
        .wr_gate_n       (wr_gate_n),
        .done            (done),
        .underrun        (underrun)
    );

    mfm_interval_timer #(
        .SHORT_LEN (SHORT_LEN),
        .MEDIUM_LEN(MEDIUM_LEN),
        .LONG_LEN  (LONG_LEN),
        .PULSE_LEN (PULSE_LEN)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_valid  (pend_valid),
        .pend_kind   (pend_kind),
        .take        (tmr_take),
        .busy        (tmr_busy),
        .expire_empty(tmr_expire_empty),
        .pulse_n     (wr_data)
    );

    // R11
    quiet_when_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_gate_n |-> wr_data);

    // R2
    pulse_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_data) |-> !wr_gate_n);

endmodule

// File: tb/mfm_sector_writer_tb.sv
module mfm_sector_writer_tb;
    localparam int SHORT_LEN = 32;
    localparam int MED_LEN   = 48;
    localparam int LONG_LEN  = 64;
    localparam int PULSE     = 8;
    localparam int PRE_LEN   = 96;
    localparam int HALF      = SHORT_LEN / 2;
    localparam int MAXN      = 5000;
    localparam int WDOG      = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] byte_count = '0;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_ready, wr_data, wr_gate_n, done, underrun;

    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    logic [7:0] mem [0:299];
    int   src_idx = 0;
    int   stall_idx = -1;
    int   exp_iv [0:MAXN-1];
    int   n_exp = 0;
    int   falls [0:MAXN-1];
    int   nf = 0;
    int   low_run = 0;
    bit   prev_d = 1'b1;
    bit   rec_en = 1'b0;
    bit   done_seen = 1'b0;
    bit   un_seen = 1'b0;
    bit   wd_fired = 1'b0;

    always #2 clk = ~clk;

    mfm_sector_writer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .byte_count(byte_count),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .wr_data   (wr_data),
        .wr_gate_n (wr_gate_n),
        .done      (done),
        .underrun  (underrun)
    );

    assign in_valid = (src_idx != stall_idx);
    assign in_data  = mem[(src_idx < 300) ? src_idx : 0];

    always @(posedge clk) begin
        if (in_valid && in_ready) src_idx <= src_idx + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: record every falling edge of write data and pulse widths.
    always @(negedge clk) begin
        cyc++;
        if (cyc > WDOG && !wd_fired) begin
            wd_fired = 1'b1;
            check(1'b0, "watchdog", cyc, WDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
        if (rec_en) begin
            if (prev_d && !wr_data) begin
                if (nf < MAXN) falls[nf] = cyc;
                nf++;
                low_run = 1;
                check(!wr_gate_n, "R2 pulse inside gate", int'(wr_gate_n), 0);
            end else if (!wr_data) begin
                low_run++;
            end else if (!prev_d) begin
                check(low_run == PULSE, "R2 pulse width", low_run, PULSE);
            end
            if (done) begin
                done_seen = 1'b1;
                un_seen   = underrun;
            end
        end
        prev_d = wr_data;
    end

    // Expected interval list from a plain clock/data MFM expansion.
    task automatic build_expected(input int nbytes);
        int last;
        int prevb;
        n_exp = 0;
        for (int i = 0; i < PRE_LEN; i++) begin exp_iv[n_exp] = SHORT_LEN; n_exp++; end
        for (int g = 0; g < 3; g++) begin
            exp_iv[n_exp] = (g == 0) ? MED_LEN : SHORT_LEN; n_exp++;
            exp_iv[n_exp] = LONG_LEN; n_exp++;
            exp_iv[n_exp] = MED_LEN;  n_exp++;
            exp_iv[n_exp] = LONG_LEN; n_exp++;
            exp_iv[n_exp] = MED_LEN;  n_exp++;
        end
        last  = -1;
        prevb = 1;
        for (int b = 0; b < nbytes; b++) begin
            for (int j = 7; j >= 0; j--) begin
                int pos;
                int d;
                pos = 2 * (b * 8 + (7 - j));
                d   = int'(mem[b][j]);
                if (prevb == 0 && d == 0) begin
                    exp_iv[n_exp] = (pos - last) * HALF; n_exp++; last = pos;
                end
                if (d == 1) begin
                    exp_iv[n_exp] = (pos + 1 - last) * HALF; n_exp++; last = pos + 1;
                end
                prevb = d;
            end
        end
    endtask

    task automatic run_frame(input int nbytes, input int stall, input bit restart_mid);
        int lim;
        build_expected(nbytes);
        nf = 0; src_idx = 0; stall_idx = stall;
        done_seen = 1'b0; un_seen = 1'b0; rec_en = 1'b1;
        @(negedge clk);
        start = 1'b1; byte_count = 16'(nbytes);
        @(negedge clk);
        start = 1'b0;
        check(wr_gate_n == 1'b0, "R1 gate low after start", int'(wr_gate_n), 0);
        if (restart_mid) begin
            repeat (500) @(negedge clk);
            start = 1'b1; byte_count = 16'(nbytes + 5);
            @(negedge clk);
            start = 1'b0; byte_count = '0;
        end
        while (!done_seen) @(negedge clk);
        lim = (nf - 1 < n_exp) ? nf - 1 : n_exp;
        for (int k = 0; k < lim; k++) begin
            int d;
            d = falls[k + 1] - falls[k];
            if (k < PRE_LEN)
                check(d == exp_iv[k], "R4/R10 preamble interval", d, exp_iv[k]);
            else if (k < PRE_LEN + 15)
                check(d == exp_iv[k], "R5/R10 sync interval", d, exp_iv[k]);
            else
                check(d == exp_iv[k], "R3/R6/R7/R8/R10 data interval", d, exp_iv[k]);
        end
        if (stall < 0) begin
            check(nf == n_exp + 1, "R11 transition count", nf, n_exp + 1);
            check(src_idx == nbytes, "R9 bytes taken", src_idx, nbytes);
            check(un_seen == 1'b0, "R12 no underrun", int'(un_seen), 0);
            if (restart_mid) check(src_idx == nbytes, "R1 restart ignored", src_idx, nbytes);
        end else begin
            check(un_seen == 1'b1, "R12 underrun flagged", int'(un_seen), 1);
            check(nf < n_exp + 1, "R12 write aborted early", nf, n_exp + 1);
            check(src_idx == stall, "R12 bytes before stall", src_idx, stall);
        end
        check(wr_gate_n == 1'b1 && wr_data == 1'b1, "R11 released and quiet",
              int'({wr_gate_n, wr_data}), 3);
        @(negedge clk);
        check(done == 1'b0, "R11 done single cycle", int'(done), 0);
        repeat (100) @(negedge clk);
        check(nf <= n_exp + 1 && wr_data == 1'b1, "R12/R11 no pulses after release",
              int'(wr_data), 1);
        rec_en = 1'b0;
        stall_idx = -1;
    endtask

    initial begin
        for (int i = 0; i < 300; i++) mem[i] = 8'(i);
        repeat (3) @(negedge clk);
        check(wr_gate_n == 1'b1, "R13 gate after reset", int'(wr_gate_n), 1);
        check(wr_data == 1'b1, "R13 data after reset", int'(wr_data), 1);
        check(done == 1'b0 && underrun == 1'b0, "R13 flags after reset",
              int'({done, underrun}), 0);
        check(in_ready == 1'b0, "R13 ready after reset", int'(in_ready), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_frame(0, -1, 1'b0);                          // R9 empty buffer
        mem[0] = 8'h00; run_frame(1, -1, 1'b0);          // R6 zeros
        mem[0] = 8'hFF; run_frame(1, -1, 1'b0);          // R7 ones
        mem[0] = 8'hA1; mem[1] = 8'h4E; mem[2] = 8'h01;
        run_frame(3, -1, 1'b1);                          // R1 restart ignored, R8
        for (int i = 0; i < 256; i++) mem[i] = 8'(i);
        run_frame(256, -1, 1'b0);                        // every byte value
        mem[0] = 8'hFB; mem[1] = 8'h55; mem[2] = 8'h33; mem[3] = 8'hCC;
        run_frame(4, 2, 1'b0);                           // R12 stall

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule